// File: doc/BRIEF.md
# Page Write Load Controller

This block gathers single-entry load strobes for a non-volatile array into a page buffer, then commits them in one internal programming operation. The first accepted load of an operation latches the page number from the upper address bits. Later loads must name that same page. A load strobe from the host carries an address and a data value. The low address bits pick one of the entries in the page.

The load phase stays open as long as loads keep arriving. Each accepted load restarts an inactivity window, which is measured in pulses of a free-running timebase input. When the window runs out without a new load, the block turns busy and waits out a fixed programming time, also counted in timebase pulses. It then issues one commit request per loaded entry to the array, and returns to idle after the last one.

Entries that were never loaded produce no commit, so the array keeps their old contents. While busy, the block ignores load strobes. A load that names a different page during the load phase is dropped, and it sets a sticky error flag.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, `busy`, `commit_valid` and `page_err` are 0, and `page_locked` is 0.
- R2: In idle, a strobe is always accepted and starts an operation. `page_locked` then takes the page field `ld_addr[14:6]` and holds it until the operation ends. The entry index is `ld_addr[5:0]`.
- R3: During the load phase, a strobe whose page field differs from `page_locked` is dropped. Its data is never committed, and it does not restart the window. `page_err` rises one cycle after the strobe and stays at 1 until reset.
- R4: The window is retriggerable. `busy` rises exactly `WIN_TICKS` timebase pulses after the last accepted load. If a load arrives in the same cycle as the pulse that would expire the window, the load wins and the window restarts.
- R5: The window and programming counters advance only in cycles where `tick` is 1.
- R6: Loading the same entry again within one operation replaces its data. That entry is committed once, with the last value.
- R7: Only loaded entries are committed. Commits come one per cycle, in ascending entry order, with `commit_addr = {page_locked, entry}` and the buffered data.
- R8: While `busy` is 1, load strobes have no effect. They do not change the commits, `page_locked` or `page_err`, and they do not start a new operation.
- R9: Commits begin exactly `PROG_TICKS` pulses after `busy` rises. `commit_valid` is only 1 while `busy` is 1. `busy` falls in the cycle after the last commit.
- R10: An operation may load 1 to 64 entries. A full page gives 64 commits. The loaded set is cleared when a new operation starts, so entries from an earlier operation are not committed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse that paces the window and the programming time |
| ld_valid | input | 1 | Load strobe, one cycle per load |
| ld_addr | input | 15 | Load address: page in [14:6], entry in [5:0] |
| ld_data | input | 8 | Load data |
| busy | output | 1 | Programming and commit in progress |
| commit_valid | output | 1 | Commit request to the array this cycle |
| commit_addr | output | 15 | Array address of the commit |
| commit_data | output | 8 | Data to write at `commit_addr` |
| page_locked | output | 9 | Page number of the current or last operation |
| page_err | output | 1 | Sticky flag: a load with the wrong page was dropped |

## Verification
The critical collision is a load strobe landing on the exact timebase pulse that would close the window. The bench spaces a second load so that its accepting edge is the `WIN_TICKS`-th pulse after the first one. It then expects `busy` to stay low and to rise only `WIN_TICKS` pulses after that second load, with both entries committed. A second overlap places a wrong-page load and a foreign load strobe inside the window and inside the busy period. The bench judges these by the exact cycle in which `busy` rises, by the commit stream checked against a scoreboard queue, and by `page_err` and `page_locked` read at the ports.

// File: rtl/ple_pkg.sv
package ple_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_PROG   = 2'd2,
        ST_COMMIT = 2'd3
    } ple_state_e;

endpackage

// File: rtl/ple_tick_counter.sv
// Counts timebase steps from a clear; flags the final step before LIMIT.
module ple_tick_counter #(
    parameter int LIMIT = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/ple_page_buffer.sv
// Data storage for one page: one write port, one combinational read port.
module ple_page_buffer #(
    parameter int DATA_W     = 8,
    parameter int ENTRY_BITS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ENTRY_BITS-1:0] wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ENTRY_BITS-1:0] rd_idx,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int ENTRIES = 1 << ENTRY_BITS;

    logic [DATA_W-1:0] mem_d [ENTRIES];
    logic [DATA_W-1:0] mem_q [ENTRIES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/ple_low_pick.sv
// Selects the lowest set bit of a request vector.
module ple_low_pick #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g]  = req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                idx = idx | IW'(i);
            end
        end
    end

endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
    import ple_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ENTRY_BITS = 6,
    parameter int PAGE_BITS  = 9,
    parameter int WIN_TICKS  = 150,
    parameter int PROG_TICKS = 10000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic                            ld_valid,
    input  logic [PAGE_BITS+ENTRY_BITS-1:0] ld_addr,
    input  logic [DATA_W-1:0]               ld_data,
    output logic                            busy,
    output logic                            commit_valid,
    output logic [PAGE_BITS+ENTRY_BITS-1:0] commit_addr,
    output logic [DATA_W-1:0]               commit_data,
    output logic [PAGE_BITS-1:0]            page_locked,
    output logic                            page_err
);
    localparam int AW      = PAGE_BITS + ENTRY_BITS;
    localparam int ENTRIES = 1 << ENTRY_BITS;

    typedef struct packed {
        ple_state_e           st;
        logic [PAGE_BITS-1:0] page;
        logic [ENTRIES-1:0]   mask;
        logic                 err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [PAGE_BITS-1:0]  ld_page;
    logic [ENTRY_BITS-1:0] ld_entry;
    logic                  page_hit;
    logic                  accept;
    logic                  reject;
    logic                  win_step;
    logic                  win_last;
    logic                  expire;
    logic                  prog_step;
    logic                  prog_last;
    logic                  prog_done;
    logic [ENTRIES-1:0]    pick_grant;
    logic [ENTRY_BITS-1:0] pick_idx;
    logic                  pick_any;
    logic [ENTRIES-1:0]    mask_left;

    assign ld_page  = ld_addr[AW-1:ENTRY_BITS];
    assign ld_entry = ld_addr[ENTRY_BITS-1:0];
    assign page_hit = (ld_page == ctl_q.page);

    // Strobes count only in idle or the load phase; busy drops them.
    assign accept = ld_valid && ((ctl_q.st == ST_IDLE) ||
                                 ((ctl_q.st == ST_LOAD) && page_hit));
    assign reject = ld_valid && (ctl_q.st == ST_LOAD) && !page_hit;

    // A load in the expiring cycle wins over the timeout.
    assign win_step  = (ctl_q.st == ST_LOAD) && tick && !accept;
    assign expire    = win_step && win_last;
    assign prog_step = (ctl_q.st == ST_PROG) && tick;
    assign prog_done = prog_step && prog_last;

    ple_tick_counter #(.LIMIT(WIN_TICKS)) u_win_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    (win_step),
        .at_last (win_last)
    );

    ple_tick_counter #(.LIMIT(PROG_TICKS)) u_prog_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (expire),
        .step    (prog_step),
        .at_last (prog_last)
    );

    ple_page_buffer #(
        .DATA_W     (DATA_W),
        .ENTRY_BITS (ENTRY_BITS)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_idx  (ld_entry),
        .wr_data (ld_data),
        .rd_idx  (pick_idx),
        .rd_data (commit_data)
    );

    ple_low_pick #(
        .N  (ENTRIES),
        .IW (ENTRY_BITS)
    ) u_pick (
        .req   (ctl_q.mask),
        .grant (pick_grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign mask_left = ctl_q.mask & ~pick_grant;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.st   = ST_LOAD;
                    ctl_d.page = ld_page;
                    ctl_d.mask = ENTRIES'(1) << ld_entry;
                end
            end
            ST_LOAD: begin
                if (accept) begin
                    ctl_d.mask = ctl_q.mask | (ENTRIES'(1) << ld_entry);
                end else if (reject) begin
                    ctl_d.err = 1'b1;
                end
                if (expire) begin
                    ctl_d.st = ST_PROG;
                end
            end
            ST_PROG: begin
                if (prog_done) begin
                    ctl_d.st = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                ctl_d.mask = mask_left;
                if (mask_left == '0) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, page: '0, mask: '0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy         = (ctl_q.st == ST_PROG) || (ctl_q.st == ST_COMMIT);
    assign commit_valid = (ctl_q.st == ST_COMMIT) && pick_any;
    assign commit_addr  = {ctl_q.page, pick_idx};
    assign page_locked  = ctl_q.page;
    assign page_err     = ctl_q.err;

endmodule

// File: rtl/ple_load_ctrl_chk.sv
module ple_load_ctrl_chk #(
    parameter int PAGE_BITS  = 9,
    parameter int ENTRY_BITS = 6
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            busy,
    input logic                            commit_valid,
    input logic [PAGE_BITS+ENTRY_BITS-1:0] commit_addr,
    input logic [PAGE_BITS-1:0]            page_locked,
    input logic                            page_err
);
    a_r9_commit_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> busy);

    a_r9_busy_ends_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit_valid));

    a_r2_page_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_locked));

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);

    a_r8_no_err_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !page_err) |=> !page_err);

    a_r7_commit_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (commit_addr[PAGE_BITS+ENTRY_BITS-1:ENTRY_BITS] == page_locked));

endmodule

bind page_load_ctrl ple_load_ctrl_chk #(
    .PAGE_BITS  (PAGE_BITS),
    .ENTRY_BITS (ENTRY_BITS)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .commit_valid (commit_valid),
    .commit_addr  (commit_addr),
    .page_locked  (page_locked),
    .page_err     (page_err)
);

// File: tb/test_page_load_ctrl.sv
module test_page_load_ctrl;
    localparam int WIN  = 8;
    localparam int PROG = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        ld_valid = 1'b0;
    logic [14:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        busy;
    logic        commit_valid;
    logic [14:0] commit_addr;
    logic [7:0]  commit_data;
    logic [8:0]  page_locked;
    logic        page_err;

    page_load_ctrl #(
        .DATA_W(8), .ENTRY_BITS(6), .PAGE_BITS(9),
        .WIN_TICKS(WIN), .PROG_TICKS(PROG)
    ) i_page_load_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
        .busy(busy), .commit_valid(commit_valid), .commit_addr(commit_addr),
        .commit_data(commit_data), .page_locked(page_locked), .page_err(page_err)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_vec  = 0;
    int n_fail = 0;
    int n_commit = 0;
    bit done = 1'b0;

    logic [22:0] exp_q[$];
    logic [63:0] m_mask = '0;
    logic [7:0]  m_data [64];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Monitor: pop and compare each commit
    always @(negedge clk) begin
        if (rst_n && commit_valid) begin
            n_vec++;
            n_commit++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R7 unexpected commit: actual %0h/%0h expected none",
                         commit_addr, commit_data);
            end else begin
                logic [22:0] e;
                e = exp_q.pop_front();
                if ({commit_addr, commit_data} !== e) begin
                    n_fail++;
                    $display("FAIL R7 commit: actual %0h/%0h expected %0h/%0h",
                             commit_addr, commit_data, e[22:8], e[7:0]);
                end
            end
        end
    end

    task automatic do_load(input logic [8:0] pg, input logic [5:0] en, input logic [7:0] dat);
        ld_valid = 1'b1;
        ld_addr  = {pg, en};
        ld_data  = dat;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_put(input logic [5:0] en, input logic [7:0] dat);
        m_mask[en] = 1'b1;
        m_data[en] = dat;
    endtask

    // Push expected commits in ascending entry order; clear model mask
    task automatic model_flush(input logic [8:0] pg);
        for (int i = 0; i < 64; i++) begin
            if (m_mask[i]) exp_q.push_back({pg, 6'(i), m_data[i]});
        end
        m_mask = '0;
    endtask

    task automatic wait_idle(input string tag, input int want);
        int start;
        start = n_commit;
        while (busy !== 1'b0 || exp_q.size() != 0) @(negedge clk);
        chk(n_commit - start == want, tag, n_commit - start, want);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual hung expected idle");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(commit_valid == 1'b0, "R1 commit_valid", commit_valid, 0);
        chk(page_err == 1'b0, "R1 page_err", page_err, 0);
        chk(page_locked == 9'd0, "R1 page_locked", page_locked, 0);

        // T1: scattered loads, reload, exact timing, ignored load while busy
        do_load(9'h005, 6'd3, 8'h11);  model_put(6'd3, 8'h11);
        idle(2);
        do_load(9'h005, 6'd63, 8'h22); model_put(6'd63, 8'h22);
        chk(page_locked == 9'h005, "R2 page lock", page_locked, 9'h005);
        idle(2);
        do_load(9'h005, 6'd10, 8'h33); model_put(6'd10, 8'h33);
        do_load(9'h005, 6'd3, 8'h44);  model_put(6'd3, 8'h44);  // R6 reload
        model_flush(9'h005);
        idle(WIN - 1);
        chk(busy == 1'b0, "R4 busy before window end", busy, 0);
        idle(1);
        chk(busy == 1'b1, "R4 busy at window end", busy, 1);
        do_load(9'h077, 6'd0, 8'hEE);  // R8 ignored while busy
        chk(page_err == 1'b0, "R8 err untouched", page_err, 0);
        chk(page_locked == 9'h005, "R8 page untouched", page_locked, 9'h005);
        idle(PROG - 2);
        chk(commit_valid == 1'b0, "R9 no commit during prog", commit_valid, 0);
        idle(1);
        chk(commit_valid == 1'b1, "R9 commit after prog", commit_valid, 1);
        wait_idle("R6 R7 commit count", 3);
        idle(WIN + PROG + 5);
        chk(busy == 1'b0, "R8 ignored load started nothing", busy, 0);

        // T3: load on the expiring pulse wins (R4)
        do_load(9'h00A, 6'd5, 8'h55);  model_put(6'd5, 8'h55);
        idle(WIN - 1);
        chk(busy == 1'b0, "R4 before collision", busy, 0);
        do_load(9'h00A, 6'd6, 8'h66);  model_put(6'd6, 8'h66);
        model_flush(9'h00A);
        chk(busy == 1'b0, "R4 collision keeps window open", busy, 0);
        idle(WIN - 1);
        chk(busy == 1'b0, "R4 rearmed window", busy, 0);
        idle(1);
        chk(busy == 1'b1, "R4 rearmed expiry", busy, 1);
        wait_idle("R4 commit count", 2);

        // T4: timebase gating (R5)
        tick = 1'b0;
        do_load(9'h100, 6'd9, 8'h77);  model_put(6'd9, 8'h77);
        model_flush(9'h100);
        idle(40);
        chk(busy == 1'b0, "R5 no tick no expiry", busy, 0);
        tick = 1'b1;
        idle(WIN - 1);
        chk(busy == 1'b0, "R5 ticks before expiry", busy, 0);
        idle(1);
        chk(busy == 1'b1, "R5 expiry after ticks", busy, 1);
        wait_idle("R5 commit count", 1);

        // T5: full page in reverse order, then a fresh single-entry operation (R10)
        for (int i = 63; i >= 0; i--) begin
            do_load(9'h1FF, 6'(i), 8'(i * 3 + 1) ^ 8'h5A);
            model_put(6'(i), 8'(i * 3 + 1) ^ 8'h5A);
        end
        model_flush(9'h1FF);
        wait_idle("R10 full page commits", 64);
        do_load(9'h1FF, 6'd7, 8'h99);  model_put(6'd7, 8'h99);
        model_flush(9'h1FF);
        wait_idle("R10 mask cleared", 1);

        // T2: wrong page dropped, sticky error, no retrigger (R3)
        do_load(9'h01A, 6'd1, 8'hA1);  model_put(6'd1, 8'hA1);
        model_flush(9'h01A);
        idle(1);
        do_load(9'h01B, 6'd2, 8'hB2);
        chk(page_err == 1'b1, "R3 err set", page_err, 1);
        chk(page_locked == 9'h01A, "R3 page kept", page_locked, 9'h01A);
        idle(WIN - 3);
        chk(busy == 1'b0, "R3 before original expiry", busy, 0);
        idle(1);
        chk(busy == 1'b1, "R3 no retrigger", busy, 1);
        wait_idle("R3 dropped data not committed", 1);
        chk(page_err == 1'b1, "R3 err sticky", page_err, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule